// File: doc/BRIEF.md
# Banked Stack-Pointer Control Register File

This block is the control-register file of a small processor core. It keeps the processor status byte and the copy of it saved on exception entry, a second-level saved status byte, the condition flag, two saved return addresses, two spare general-purpose words and a pair of stack pointers. Only one of the two stack pointers is live at a time. Software reaches all of them through one combinational read port and one clocked write port, each addressed by a 4-bit control-register number.

The live stack pointer is also exported on its own port, because the general register file uses it as its stack-pointer entry. The general register file can write it back through a dedicated write port. Bit 7 of the status byte selects the stack mode. When a status write flips that bit, the live pointer is parked in the shadow that belongs to the old mode, and the shadow for the new mode becomes live, all on the same clock edge.

The register numbers are: 0 status, 1 condition flag, 2 interrupt stack pointer, 3 user stack pointer, 4 and 5 spare words, 6 and 7 saved return addresses, and 8 second-level saved status. Numbers 9 to 15 are unmapped.

Top module: `ctrlreg_file`

## Requirements
- R1: After a synchronous active-high reset, every register number reads 0 and `sp_live` is 0.
- R2: Reading number 0 returns a word with the following bits and all others zero: saved status bits 7, 6 and 0 at positions 15, 14 and 8; current status bits 7 and 6 at positions 7 and 6; the condition flag at position 0.
- R3: A write to number 0 loads data bits 15:8 into the saved status byte and bits 7:0 into the status byte, and copies data bit 0 into the condition flag.
- R4: A status write that changes the mode bit (status bit 7) from 1 to 0 copies the live pointer into the user shadow and loads the live pointer from the interrupt shadow.
- R5: A status write that changes the mode bit from 0 to 1 copies the live pointer into the interrupt shadow and loads the live pointer from the user shadow.
- R6: Number 2 reads and writes the live pointer while the mode bit is 0, and the interrupt shadow while it is 1. Number 3 reads and writes the live pointer while the mode bit is 1, and the user shadow while it is 0.
- R7: Numbers 6 and 7 accept a full 32-bit write and always read back with bit 0 cleared.
- R8: Number 8 takes the low byte of a write and reads back that byte ANDed with 0xC1. Number 1 reads and writes only bit 0, which is the condition flag shared with number 0.
- R9: Numbers 4 and 5 are plain 32-bit read/write words. Numbers 9 to 15 read as 0, and writes to them change no register.
- R10: When `gpr_sp_we` is high, `sp_live` takes `gpr_sp_wdata` at the next edge, unless a control write in the same cycle updates the live pointer (a mode-flipping status write, or a write through number 2 or 3 that maps to the live pointer). In that case the control write wins.
- R11: `rd_data` follows `rd_idx` and the current register state combinationally. Writes take effect at the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control-register write strobe |
| wr_idx | input | 4 | Register number for the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 4 | Register number for the read |
| rd_data | output | 32 | Read data, combinational |
| gpr_sp_we | input | 1 | Live stack-pointer write from the general register file |
| gpr_sp_wdata | input | 32 | Data for that write |
| sp_live | output | 32 | Current live stack pointer |

## Verification
The bench flips the mode bit in both directions with different values in the live pointer and both shadows. A design that swaps the wrong pair, or that loads the live pointer before saving it, then shows a wrong value on `sp_live` or on numbers 2 and 3. It also writes the status register without changing the mode, which must leave the pointers where they are. It collides a general-register stack write with control writes that do and do not reach the live pointer: a wrong priority shows up as the discarded value appearing on `sp_live`. Writes of all ones to the masked registers, the return-address registers and the unmapped numbers expose any leaked bit, a set bit 0, or an aliased register.

// File: rtl/ctrlreg_pkg.sv
package ctrlreg_pkg;

    parameter int unsigned DATA_W   = 32;
    parameter int unsigned CR_IDX_W = 4;
    localparam int unsigned BYTE_W  = 8;

    // Register numbers; 9..15 are unmapped
    typedef enum logic [CR_IDX_W-1:0] {
        CR_STATUS  = 4'd0,
        CR_COND    = 4'd1,
        CR_ISTACK  = 4'd2,
        CR_USTACK  = 4'd3,
        CR_SPARE0  = 4'd4,
        CR_SPARE1  = 4'd5,
        CR_RETPC   = 4'd6,
        CR_RETPC2  = 4'd7,
        CR_STATUS2 = 4'd8
    } cr_idx_e;

    localparam logic [CR_IDX_W-1:0] CR_LAST_MAPPED = CR_STATUS2;

    // Write request bundle
    typedef struct packed {
        logic                en;
        logic [CR_IDX_W-1:0] idx;
        logic [DATA_W-1:0]   data;
    } cr_wr_t;

    // Only the visible bits of the status bytes are stored
    typedef struct packed {
        logic [1:0] cur_hi;   // status bits 7:6, bit 7 is the stack mode
        logic [2:0] bkp_kept; // saved status bits 7,6,0
        logic       cond;     // condition flag
    } status_t;

    function automatic logic [2:0] keep_c1(input logic [BYTE_W-1:0] b);
        return {b[7], b[6], b[0]};
    endfunction

    function automatic logic [BYTE_W-1:0] expand_c1(input logic [2:0] k);
        return {k[2], k[1], 5'b0, k[0]};
    endfunction

endpackage

// File: rtl/ctrlreg_status.sv
module ctrlreg_status
    import ctrlreg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cr_wr_t  wr,
    output status_t st_q,
    output logic [2:0] bk2_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            bk2_q <= '0;
        end else if (wr.en) begin
            case (wr.idx)
                CR_STATUS: begin
                    st_q.cur_hi   <= wr.data[7:6];
                    st_q.bkp_kept <= keep_c1(wr.data[15:8]);
                    st_q.cond     <= wr.data[0];
                end
                CR_COND:    st_q.cond <= wr.data[0];
                CR_STATUS2: bk2_q     <= keep_c1(wr.data[7:0]);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ctrlreg_stack.sv
module ctrlreg_stack
    import ctrlreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cr_wr_t            wr,
    input  logic              mode_q,
    input  logic              gpr_we,
    input  logic [DATA_W-1:0] gpr_data,
    output logic [DATA_W-1:0] live_q,
    output logic [DATA_W-1:0] ist_view,
    output logic [DATA_W-1:0] ust_view
);

    logic [DATA_W-1:0] ish_q;
    logic [DATA_W-1:0] ush_q;
    logic flip;
    logic wr_ist;
    logic wr_ust;
    logic ctrl_live;

    always_comb begin
        flip      = wr.en && (wr.idx == CR_STATUS) && (wr.data[7] != mode_q);
        wr_ist    = wr.en && (wr.idx == CR_ISTACK);
        wr_ust    = wr.en && (wr.idx == CR_USTACK);
        ctrl_live = (wr_ist && !mode_q) || (wr_ust && mode_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            ish_q  <= '0;
            ush_q  <= '0;
        end else if (flip) begin
            if (mode_q) begin
                ush_q  <= live_q;
                live_q <= ish_q;
            end else begin
                ish_q  <= live_q;
                live_q <= ush_q;
            end
        end else begin
            if (ctrl_live)
                live_q <= wr.data;
            else if (gpr_we)
                live_q <= gpr_data;
            if (wr_ist && mode_q)
                ish_q <= wr.data;
            if (wr_ust && !mode_q)
                ush_q <= wr.data;
        end
    end

    assign ist_view = mode_q ? ish_q  : live_q;
    assign ust_view = mode_q ? live_q : ush_q;

endmodule

// File: rtl/ctrlreg_bank.sv
module ctrlreg_bank
    import ctrlreg_pkg::*;
#(
    parameter int unsigned N_WORDS  = 2,
    parameter int unsigned BASE_IDX = 4,
    parameter bit          HOLD_LSB = 1'b1
)(
    input  logic   clk,
    input  logic   rst,
    input  cr_wr_t wr,
    output logic [N_WORDS-1:0][DATA_W-1:0] words
);

    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        localparam logic [CR_IDX_W-1:0] MY_IDX = CR_IDX_W'(BASE_IDX + g);
        logic hit;
        assign hit = wr.en && (wr.idx == MY_IDX);

        if (HOLD_LSB) begin : g_full
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)      q <= '0;
                else if (hit) q <= wr.data;
            end
            assign words[g] = q;
        end else begin : g_even
            logic [DATA_W-1:1] q;
            always_ff @(posedge clk) begin
                if (rst)      q <= '0;
                else if (hit) q <= wr.data[DATA_W-1:1];
            end
            assign words[g] = {q, 1'b0};
        end
    end

endmodule

// File: rtl/ctrlreg_file.sv
module ctrlreg_file
    import ctrlreg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [CR_IDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [CR_IDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                gpr_sp_we,
    input  logic [DATA_W-1:0]   gpr_sp_wdata,
    output logic [DATA_W-1:0]   sp_live
);

    cr_wr_t  wr;
    status_t st_q;
    logic [2:0] bk2_q;
    logic    mode_q;
    logic [DATA_W-1:0] ist_view;
    logic [DATA_W-1:0] ust_view;
    logic [1:0][DATA_W-1:0] spare_w;
    logic [1:0][DATA_W-1:0] retpc_w;

    assign wr     = '{en: wr_en, idx: wr_idx, data: wr_data};
    assign mode_q = st_q.cur_hi[1];

    ctrlreg_status u_status (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr),
        .st_q  (st_q),
        .bk2_q (bk2_q)
    );

    ctrlreg_stack u_stack (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .mode_q   (mode_q),
        .gpr_we   (gpr_sp_we),
        .gpr_data (gpr_sp_wdata),
        .live_q   (sp_live),
        .ist_view (ist_view),
        .ust_view (ust_view)
    );

    ctrlreg_bank #(.N_WORDS(2), .BASE_IDX(CR_SPARE0), .HOLD_LSB(1'b1)) u_spare (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr),
        .words (spare_w)
    );

    ctrlreg_bank #(.N_WORDS(2), .BASE_IDX(CR_RETPC), .HOLD_LSB(1'b0)) u_retpc (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr),
        .words (retpc_w)
    );

    always_comb begin
        rd_data = '0;
        case (rd_idx)
            CR_STATUS:  rd_data = DATA_W'({expand_c1(st_q.bkp_kept), st_q.cur_hi, 5'b0, st_q.cond});
            CR_COND:    rd_data = DATA_W'(st_q.cond);
            CR_ISTACK:  rd_data = ist_view;
            CR_USTACK:  rd_data = ust_view;
            CR_SPARE0:  rd_data = spare_w[0];
            CR_SPARE1:  rd_data = spare_w[1];
            CR_RETPC:   rd_data = retpc_w[0];
            CR_RETPC2:  rd_data = retpc_w[1];
            CR_STATUS2: rd_data = DATA_W'(expand_c1(bk2_q));
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ctrlreg_file_chk.sv
module ctrlreg_file_chk
    import ctrlreg_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [CR_IDX_W-1:0] wr_idx,
    input logic [DATA_W-1:0]   wr_data,
    input logic [CR_IDX_W-1:0] rd_idx,
    input logic [DATA_W-1:0]   rd_data,
    input logic                gpr_sp_we,
    input logic [DATA_W-1:0]   gpr_sp_wdata,
    input logic [DATA_W-1:0]   sp_live,
    input logic                mode_q,
    input logic [DATA_W-1:0]   ist_view,
    input logic [DATA_W-1:0]   ust_view
);

    p_status_mask_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == CR_STATUS) |-> ((rd_data & ~DATA_W'(32'h0000_C1C1)) == '0));

    p_swap_to_intr_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == CR_STATUS && mode_q && !wr_data[7])
        |=> (sp_live == $past(ist_view)) && (ust_view == $past(sp_live)));

    p_swap_to_user_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == CR_STATUS && !mode_q && wr_data[7])
        |=> (sp_live == $past(ust_view)) && (ist_view == $past(sp_live)));

    p_retpc_even_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == CR_RETPC || rd_idx == CR_RETPC2) |-> !rd_data[0]);

    p_cond_width_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == CR_COND) |-> (rd_data[DATA_W-1:1] == '0));

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_idx > CR_LAST_MAPPED) |-> (rd_data == '0));

    p_gpr_write_r10: assert property (@(posedge clk) disable iff (rst)
        (gpr_sp_we && !wr_en) |=> (sp_live == $past(gpr_sp_wdata)));

    p_ctrl_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (gpr_sp_we && wr_en && wr_idx == CR_ISTACK && !mode_q)
        |=> (sp_live == $past(wr_data)));

endmodule

bind ctrlreg_file ctrlreg_file_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data),
    .rd_idx       (rd_idx),
    .rd_data      (rd_data),
    .gpr_sp_we    (gpr_sp_we),
    .gpr_sp_wdata (gpr_sp_wdata),
    .sp_live      (sp_live),
    .mode_q       (mode_q),
    .ist_view     (ist_view),
    .ust_view     (ust_view)
);

// File: tb/test_ctrlreg_file.sv
`timescale 1ns/1ps
module test_ctrlreg_file;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        gpr_sp_we = 1'b0;
    logic [31:0] gpr_sp_wdata = '0;
    logic [31:0] sp_live;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ctrlreg_file i_ctrlreg_file (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_data      (wr_data),
        .rd_idx       (rd_idx),
        .rd_data      (rd_data),
        .gpr_sp_we    (gpr_sp_we),
        .gpr_sp_wdata (gpr_sp_wdata),
        .sp_live      (sp_live)
    );

    // Behavioural reference state (full bytes kept, masked on read)
    logic [7:0]  m_sts, m_bsts, m_bsts2;
    logic        m_cond;
    logic [31:0] m_live, m_ish, m_ush;
    logic [31:0] m_word [4:7];

    task automatic model_reset();
        m_sts = 0; m_bsts = 0; m_bsts2 = 0; m_cond = 0;
        m_live = 0; m_ish = 0; m_ush = 0;
        for (int i = 4; i <= 7; i++) m_word[i] = 0;
    endtask

    function automatic logic [31:0] model_read(input int idx);
        case (idx)
            0: return {16'h0, m_bsts & 8'hC1, (m_sts & 8'hC0) | {7'b0, m_cond}};
            1: return {31'b0, m_cond};
            2: return m_sts[7] ? m_ish : m_live;
            3: return m_sts[7] ? m_live : m_ush;
            4, 5: return m_word[idx];
            6, 7: return m_word[idx] & 32'hFFFF_FFFE;
            8: return {24'h0, m_bsts2 & 8'hC1};
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_edge();
        logic [31:0] nlive;
        int idx;
        idx   = int'(wr_idx);
        nlive = gpr_sp_we ? gpr_sp_wdata : m_live;
        if (wr_en) begin
            case (idx)
                0: begin
                    if (wr_data[7] != m_sts[7]) begin
                        if (m_sts[7]) begin m_ush = m_live; nlive = m_ish; end
                        else          begin m_ish = m_live; nlive = m_ush; end
                    end
                    m_bsts = wr_data[15:8];
                    m_sts  = wr_data[7:0];
                    m_cond = wr_data[0];
                end
                1: m_cond = wr_data[0];
                2: if (m_sts[7]) m_ish = wr_data; else nlive = wr_data;
                3: if (m_sts[7]) nlive = wr_data; else m_ush = wr_data;
                4, 5, 6, 7: m_word[idx] = wr_data;
                8: m_bsts2 = wr_data[7:0];
                default: ;
            endcase
        end
        m_live = nlive;
    endtask

    task automatic compare(input string tag);
        logic [31:0] exp_rd;
        exp_rd = model_read(int'(rd_idx));
        n_cmp++;
        if (rd_data !== exp_rd) begin
            n_bad++;
            $display("FAIL %s rd_idx=%0d rd_data actual=%h expected=%h", tag, rd_idx, rd_data, exp_rd);
        end
        n_cmp++;
        if (sp_live !== m_live) begin
            n_bad++;
            $display("FAIL %s sp_live actual=%h expected=%h", tag, sp_live, m_live);
        end
    endtask

    // Drive after a falling edge, compare, then advance the model at the rising edge
    task automatic step(input bit we, input int widx, input logic [31:0] wd,
                        input int ridx, input bit gwe, input logic [31:0] gd,
                        input string tag);
        @(negedge clk);
        wr_en = we; wr_idx = 4'(widx); wr_data = wd;
        rd_idx = 4'(ridx); gpr_sp_we = gwe; gpr_sp_wdata = gd;
        #1;
        compare(tag);
        @(posedge clk);
        model_edge();
    endtask

    task automatic rd(input int ridx, input string tag);
        step(1'b0, 0, 32'h0, ridx, 1'b0, 32'h0, tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: everything zero after reset
        for (int i = 0; i < 16; i++) rd(i, "R1 reset state");

        // R10: general register file writes the live pointer
        step(1, 12, 32'hFFFF_FFFF, 2, 1, 32'h0000_1000, "R10 gpr write, R9 unmapped write");
        rd(2, "R6 istack is live in mode 0");
        step(1, 3, 32'h0000_2000, 3, 0, 0, "R6 ustack write to shadow");
        rd(3, "R6 ustack shadow readback");
        rd(2, "R6 istack still live");

        // R5 and R3: enter mode 1
        step(1, 0, 32'h0000_FF81, 0, 0, 0, "R5 mode 0->1 write");
        rd(0, "R3 R2 status fields");
        rd(2, "R5 interrupt shadow saved");
        rd(3, "R5 user pointer live");
        step(1, 0, 32'h0000_00C0, 1, 0, 0, "R3 status write no mode change");
        rd(3, "R3 no swap without mode change");
        rd(1, "R3 cond cleared by status write");
        step(1, 2, 32'h0000_3000, 2, 1, 32'h0000_ABCD, "R6 istack shadow write in mode 1");
        rd(2, "R6 istack shadow readback");

        // R4: back to mode 0
        step(1, 0, 32'h0000_0040, 0, 0, 0, "R4 mode 1->0 write");
        rd(2, "R4 interrupt pointer live");
        rd(3, "R4 user shadow saved");
        rd(0, "R2 status after return");

        // R10: collisions
        step(1, 2, 32'h0000_5555, 2, 1, 32'h0000_6666, "R10 control write wins");
        step(1, 3, 32'h0000_7777, 3, 1, 32'h0000_8888, "R10 gpr wins over shadow write");
        step(1, 0, 32'h0000_0080, 0, 1, 32'h0000_9999, "R10 swap beats gpr");
        step(1, 0, 32'h0000_0000, 0, 1, 32'h0000_AAAA, "R10 swap back beats gpr");

        // R8, R7, R9
        step(1, 1, 32'hFFFF_FFFF, 1, 0, 0, "R8 cond write");
        rd(1, "R8 cond readback");
        rd(0, "R8 cond visible in status");
        step(1, 8, 32'hFFFF_FFFF, 8, 0, 0, "R8 second backup write");
        rd(8, "R8 second backup masked");
        step(1, 6, 32'hDEAD_BEEF, 6, 0, 0, "R7 retpc write");
        step(1, 7, 32'h1234_5679, 6, 0, 0, "R7 retpc readback");
        rd(7, "R7 retpc2 readback");
        step(1, 4, 32'hA5A5_5A5B, 4, 0, 0, "R9 spare write");
        step(1, 5, 32'hFFFF_FFFF, 4, 0, 0, "R9 spare readback");
        rd(5, "R9 spare2 readback");
        for (int i = 9; i < 16; i++) step(1, i, 32'hFFFF_FFFF, i, 0, 0, "R9 unmapped write");
        for (int i = 0; i < 16; i++) rd(i, "R9 nothing disturbed");

        // R11: mixed traffic, compared every cycle
        for (int n = 0; n < 400; n++) begin
            step(1'($urandom), int'($urandom_range(0, 15)), $urandom,
                 int'($urandom_range(0, 15)), 1'($urandom), $urandom,
                 "R11 mixed traffic R2 R6");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule